// File: doc/BRIEF.md
# Register-Mapped Serial Transmitter

This block is a transmit-only serial port that hangs off a simple processor load/store bus. Software programs a bit period in clock cycles, sets an enable flag, and then stores bytes into a data register. Each accepted byte leaves on a single line as an asynchronous frame: a low start bit, eight data bits least significant first, and a high stop bit. Before each store, software polls a status word to learn whether the transmitter can take another byte.

The bus port has one cycle per access. A store is captured on the clock edge where `bus_valid` and `bus_write` are both high. A load returns its word combinationally on `bus_rdata` in the same cycle. Address bits [3:2] select one of four words, and bits [1:0] are ignored. There is no queue: one byte is in flight at a time.

Top module: `serial_tx_port`

## Requirements
- R1: After reset, `tx_o` is 1, the enable flag is 0, the bit period reads back as 435, and status reads 0x1 (ready=1, busy=0).
- R2: While the enable flag (bit 0 of the word at offset 0x4) is 0, `tx_o` stays 1 and stores to offset 0x0 start no frame.
- R3: A store to offset 0x0 while the port is enabled and idle sends bits [7:0] of the write data. The frame is one 0 bit, then data bit 0 through bit 7, then one 1 bit. The start bit appears on `tx_o` in the cycle after the accepting edge.
- R4: Status at offset 0x8 has ready in bit 0 and busy in bit 1, and all other bits are 0. Busy is 1 and ready is 0 for exactly 10×D cycles, from the accepting edge until the stop bit ends, where D is the bit period in use for that frame.
- R5: A store to offset 0x0 while busy is dropped. This includes a store sampled on the very edge that ends the stop bit. A store one cycle later is accepted.
- R6: The word at offset 0xC sets the bit period in clock cycles, and each frame bit lasts that many cycles. The value is captured when a byte is accepted, so a later write changes only later frames.
- R7: Loads from offset 0x0 return 0. Offset 0x4 returns the enable flag in bit 0. Offset 0xC returns the bit period. `bus_rdata` is 0 when no load is presented.
- R8: Writing 0 to the enable flag during a frame abandons that frame. In the next cycle `tx_o` is 1 and status reads ready.
- R9: Writing 0 to the bit-period word stores 1, so the period is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 4 | Byte offset; bits [3:2] select the word |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, valid in the same cycle |
| tx_o | output | 1 | Serial line, idles high |

## Verification
The block has two colliding events: the stop bit finishing and a new byte being stored. The bench times a store so that it is sampled on exactly the edge where the stop bit's last cycle ends. It judges the outcome by three observations: that store must leave no frame on the line, status must read ready one cycle later, and a store in that cycle must start a frame with only one idle cycle before it. A second overlap is a bit-period write that lands while a frame is on the line. The scoreboard rebuilds that frame at the old period and the next frame at the new one.

// File: rtl/serial_tx_port.sv
module serial_tx_port #(
  parameter int DIV_W     = 16,
  parameter int DIV_RESET = 435
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tx_o
);
  localparam int FRAME_BITS = 10;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  logic             enable, busy;
  logic [DIV_W-1:0] period, frame_period, tick;
  logic [IDX_W-1:0] idx;
  logic [FRAME_BITS-1:0] shreg;

  wire [1:0] sel     = bus_addr[3:2];
  wire       wr      = bus_valid && bus_write;
  wire       rd      = bus_valid && !bus_write;
  wire       wr_data = wr && sel == 2'd0;
  wire       wr_ctrl = wr && sel == 2'd1;
  wire       wr_per  = wr && sel == 2'd3;
  wire       stop_en = wr_ctrl && !bus_wdata[0];
  wire       accept  = wr_data && enable && !busy;
  wire       bit_end = busy && tick == frame_period - 1'b1;

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[31:DIV_W], bus_addr[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable       <= 1'b0;
      period       <= DIV_W'(DIV_RESET);
      busy         <= 1'b0;
      shreg        <= '1;
      tick         <= '0;
      idx          <= '0;
      frame_period <= DIV_W'(1);
    end else begin
      if (wr_ctrl) enable <= bus_wdata[0];
      if (wr_per)
        period <= (bus_wdata[DIV_W-1:0] == '0) ? DIV_W'(1) : bus_wdata[DIV_W-1:0];
      if (stop_en) begin
        busy  <= 1'b0;
        shreg <= '1;
      end else if (accept) begin
        busy         <= 1'b1;
        shreg        <= {1'b1, bus_wdata[7:0], 1'b0};
        tick         <= '0;
        idx          <= '0;
        frame_period <= period;
      end else if (busy) begin
        if (bit_end) begin
          tick <= '0;
          if (idx == LAST_IDX) begin
            busy <= 1'b0;
          end else begin
            shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
            idx   <= idx + 1'b1;
          end
        end else begin
          tick <= tick + 1'b1;
        end
      end
    end
  end

  assign tx_o = busy ? shreg[0] : 1'b1;

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (sel)
        2'd1:    bus_rdata = {31'b0, enable};
        2'd2:    bus_rdata = {30'b0, busy, !busy};
        2'd3:    bus_rdata = 32'(period);
        default: bus_rdata = '0;
      endcase
    end
  end

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> tx_o); // R2
  AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && enable && !busy && !stop_en) |=> (busy && !tx_o)); // R3
  AST_BUSY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_data && enable)); // R5
  AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(frame_period)); // R6
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_en |=> (!busy && tx_o)); // R8
  AST_PERIOD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    period != '0); // R9
endmodule

// File: tb/serial_tx_port_bench.sv
module serial_tx_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_o;

  serial_tx_port u_serial_tx_port (.*);

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  bit mon_on = 1'b1;
  int cur_d = 435;
  logic [31:0] exp_q[$];

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // caller is at a negedge; access sampled at the next posedge
  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] v);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    exp_q.push_back({8'h0, 16'(cur_d), b});
    bus_wr(4'h0, {24'h0, b});
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    forever begin
      peek(4'h8, v);
      if (v[0]) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && rst_n && tx_o === 1'b0) begin
        if (exp_q.size() == 0) begin
          chk("R3 unexpected frame", 32'h1, 32'h0);
          while (tx_o !== 1'b1) @(negedge clk);
        end else begin
          logic [31:0] e;
          logic [7:0] got;
          logic st, sp;
          int d;
          e = exp_q.pop_front();
          d = int'(e[23:8]);
          repeat ((d - 1) / 2) @(negedge clk);
          st = tx_o;
          for (int i = 0; i < 8; i++) begin
            repeat (d) @(negedge clk);
            got[i] = tx_o;
          end
          repeat (d) @(negedge clk);
          sp = tx_o;
          chk("R3/R6 frame {start,data,stop}", {22'h0, st, got, sp}, {22'h0, 1'b0, e[7:0], 1'b1});
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    bit hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 tx idle", {31'h0, tx_o}, 32'h1);
    peek(4'h8, v); chk("R1 status", v, 32'h1);
    peek(4'hC, v); chk("R1 period", v, 32'd435);
    peek(4'h4, v); chk("R1 enable", v, 32'h0);
    chk("R7 rdata no load", bus_rdata, 32'h0);
    // R2 disabled: store dropped
    bus_wr(4'h0, 32'h55);
    hi = 1'b1;
    repeat (40) begin @(negedge clk); if (tx_o !== 1'b1) hi = 1'b0; end
    chk("R2 line idle while disabled", {31'h0, hi}, 32'h1);
    peek(4'h8, v); chk("R2 status still ready", v, 32'h1);
    // R7 data reads zero
    peek(4'h0, v); chk("R7 data read", v, 32'h0);
    // enable, one frame at reset period
    bus_wr(4'h4, 32'h1);
    peek(4'h4, v); chk("R7 enable read", v, 32'h1);
    send(8'hA5);
    peek(4'h8, v); chk("R4 status busy after accept", v, 32'h2);
    wait_idle();
    // R9 zero period clamps to one
    bus_wr(4'hC, 32'h0);
    peek(4'hC, v); chk("R9 period clamp", v, 32'h1);
    cur_d = 1;
    send(8'h3C);
    wait_idle();
    // R4 busy length with D=8
    bus_wr(4'hC, 32'd8); cur_d = 8;
    peek(4'hC, v); chk("R6 period read", v, 32'd8);
    send(8'h00);
    n = 0;
    forever begin
      peek(4'h8, v);
      if (v[1]) n++; else break;
      @(negedge clk);
    end
    chk("R4 busy cycles", n, 32'd80);
    chk("R4 status after frame", v, 32'h1);
    wait_idle();
    // R5 store during busy dropped
    bus_wr(4'hC, 32'd5); cur_d = 5;
    send(8'hFF);
    repeat (7) @(negedge clk);
    bus_wr(4'h0, 32'h12);
    peek(4'h8, v); chk("R5 still busy after dropped store", v, 32'h2);
    wait_idle();
    // R5 boundary: store on the edge ending the stop bit
    send(8'h81);
    repeat (10 * 5 - 1) @(negedge clk);
    bus_wr(4'h0, 32'h77);
    peek(4'h8, v); chk("R5 ready one cycle after frame end", v, 32'h1);
    send(8'h6E);
    wait_idle();
    // R6 period change mid-frame
    bus_wr(4'hC, 32'd6); cur_d = 6;
    send(8'hC3);
    repeat (20) @(negedge clk);
    bus_wr(4'hC, 32'd10);
    cur_d = 10;
    wait_idle();
    send(8'h5A);
    wait_idle();
    // R8 abort
    mon_on = 1'b0;
    bus_wr(4'hC, 32'd4); cur_d = 4;
    bus_wr(4'h0, 32'hF0);
    repeat (9) @(negedge clk);
    bus_wr(4'h4, 32'h0);
    peek(4'h8, v); chk("R8 ready after abort", v, 32'h1);
    hi = 1'b1;
    repeat (60) begin if (tx_o !== 1'b1) hi = 1'b0; @(negedge clk); end
    chk("R8 line idle after abort", {31'h0, hi}, 32'h1);
    mon_on = 1'b1;
    chk("R3 scoreboard drained", exp_q.size(), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule